// File: doc/BRIEF.md
# Banked Architectural Register Bank with Boot Loader

This block is the register state of a small 32-bit microcontroller-class core. It holds thirteen plain data registers, two physical stack pointers (a main one and a process one) behind a single index, a return-address register, the program counter, and a 32-bit status word. The status word packs condition flags, the active exception number and the instruction-set state bit. Two combinational read ports and one write port address the sixteen architectural indices 0 to 15.

Index 13 is steered to one of the two stack pointers. Handler mode always sees the main pointer. Thread mode sees the main or the process pointer, as chosen by a select bit that software sets through a control write.

Leaving reset, a small sequencer makes two word reads through a simple request/valid memory port. The first read seeds the main stack pointer and the second seeds the program counter and the instruction-set state bit. Normal register traffic is accepted only after both reads complete. An attempt to execute while the state bit is clear raises a fault.

Top module: `arch_regbank`

## Requirements
- R1: Indices 0 to 12 are plain storage: a write through the write port is returned on both read ports, and each read port selects its register independently and combinationally.
- R2: Reading or writing index 13 reaches the main stack pointer when `handler_mode` is 1, or when it is 0 and `ctrl_spsel` is 0. It reaches the process stack pointer when `handler_mode` is 0 and `ctrl_spsel` is 1. `ctrl_spsel` takes `ctrl_spsel_in` on a control write.
- R3: Under reset, `ctrl_spsel` reads 0, `running` reads 0, `mem_req` reads 0 and index 14 reads 0xFFFFFFFF. All other registers, the flags and the exception number clear to zero.
- R4: After reset is released, `mem_req` rises with `mem_addr` = 0x00000000 and holds until `mem_rvalid`. That word, with bits 1:0 cleared, becomes the main stack pointer. `mem_addr` then moves to 0x00000004. On its `mem_rvalid`, the word with bit 0 cleared becomes the program counter, and bit 0 of the word becomes the state bit. `running` is 1 from the following cycle.
- R5: While `running` is 0, the following inputs have no effect on any register: `wr_en`, `bl_strobe`, `ctrl_wr_en`, `flags_we` and `exc_we`.
- R6: A write to index 15 stores the data with bit 0 cleared. A write reaching either stack pointer stores the data with bits 1:0 cleared.
- R7: `bl_strobe` loads `bl_ret_addr` into index 14. When it coincides with a port write to index 14, the strobe wins.
- R8: `fault` is 1 in the same cycle exactly when `running`, `exec_req` and a clear state bit coincide.
- R9: `psr_word` carries flags N,Z,C,V in bits 31,30,29,28, the state bit in bit 24 and the exception number in bits 8:0. Every other bit reads zero. `flags_we` and `exc_we` update their fields independently.
- R10: While `running` is 1, `mem_req` stays 0 and `mem_rvalid`/`mem_rdata` have no effect. During a fetch with `mem_rvalid` low, `mem_rdata` is ignored and `mem_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port index |
| wr_data | input | 32 | Write port data |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| ctrl_wr_en | input | 1 | Load the stack-select bit |
| ctrl_spsel_in | input | 1 | New stack-select value |
| ctrl_spsel | output | 1 | Current stack-select bit |
| bl_strobe | input | 1 | Branch-and-link: load return address |
| bl_ret_addr | input | 32 | Return address for the strobe |
| flags_we | input | 1 | Load condition flags |
| flags_in | input | 4 | N,Z,C,V (bit 3 = N) |
| exc_we | input | 1 | Load exception number |
| exc_in | input | 9 | Exception number |
| psr_word | output | 32 | Combined status word |
| exec_req | input | 1 | Core attempts to execute this cycle |
| fault | output | 1 | Execution with state bit clear |
| mem_req | output | 1 | Boot read request |
| mem_addr | output | 32 | Boot read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| running | output | 1 | Boot complete, register traffic accepted |

## Verification
Several properties are checked on every cycle. Address hold during a fetch, a silent memory port after boot, and alignment of both stack pointers and the program counter are always checked. So are frozen return-address and select state before boot, the strobe landing in index 14, the state-bit load, fault gating and flag retention. Other behaviour shows only in the bench's scenarios. That covers the actual vector values, index-13 steering across modes and select settings, strobe-over-write priority, the status word's field layout, and the fault raised after a boot with bit 0 clear.

// File: rtl/rb_pkg.sv
// Shared constants and types for the architectural register bank.
// Assumes a 32-bit datapath and sixteen architectural indices.
package rb_pkg;
    localparam int XLEN    = 32;
    localparam int IDX_W   = 4;
    localparam int NUM_GPR = 13;
    localparam int EXC_W   = 9;
    localparam int FLAG_W  = 4;
    localparam int FLAG_HI = 31;
    localparam int TBIT_POS = 24;
    localparam logic [IDX_W-1:0] IDX_SP = 4'd13;
    localparam logic [IDX_W-1:0] IDX_LR = 4'd14;
    localparam logic [IDX_W-1:0] IDX_PC = 4'd15;

    typedef enum logic [1:0] {
        BOOT_IDLE = 2'd0,
        BOOT_SP   = 2'd1,
        BOOT_PC   = 2'd2,
        BOOT_RUN  = 2'd3
    } boot_st_e;
endpackage

// File: rtl/rb_boot_seq.sv
// Boot sequencer: after reset fetches the stack word, then the vector word,
// each waiting for its valid strobe, then stays in the run state.
// Assumes the memory returns exactly one valid per request.
module rb_boot_seq
    import rb_pkg::*;
#(
    parameter logic [XLEN-1:0] SP_ADDR = 32'h0000_0000,
    parameter logic [XLEN-1:0] PC_ADDR = 32'h0000_0004
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_rvalid,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    output logic            ld_sp,
    output logic            ld_pc,
    output logic            running
);
    boot_st_e st_q;

    // Advance through the two fetches, then hold in run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BOOT_IDLE;
        end else begin
            unique case (st_q)
                BOOT_IDLE: st_q <= BOOT_SP;
                BOOT_SP:   if (mem_rvalid) st_q <= BOOT_PC;
                BOOT_PC:   if (mem_rvalid) st_q <= BOOT_RUN;
                default:   st_q <= BOOT_RUN;
            endcase
        end
    end

    // Moore request/address plus load strobes qualified by valid.
    always_comb begin
        mem_req  = (st_q == BOOT_SP) || (st_q == BOOT_PC);
        mem_addr = (st_q == BOOT_PC) ? PC_ADDR : SP_ADDR;
        ld_sp    = (st_q == BOOT_SP) && mem_rvalid;
        ld_pc    = (st_q == BOOT_PC) && mem_rvalid;
        running  = (st_q == BOOT_RUN);
    end

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R10
    run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (running && !mem_req));
endmodule

// File: rtl/rb_gpr_file.sv
// Thirteen plain data registers with one write port and two read ports.
// Indices outside the file read as zero; the top muxes those indices.
module rb_gpr_file
    import rb_pkg::*;
#(
    parameter int NUM = NUM_GPR,
    parameter int W   = XLEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] ridx_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [W-1:0]     rdata_a,
    output logic [W-1:0]     rdata_b
);
    logic [NUM-1:0][W-1:0] regs_q;
    logic [NUM-1:0]        hit;

    // Per-register write decode.
    for (genvar g = 0; g < NUM; g++) begin : g_dec
        assign hit[g] = we && (widx == IDX_W'(g));
    end

    // Register storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if (hit[i]) regs_q[i] <= wdata;
            end
        end
    end

    // Independent combinational read selection.
    assign rdata_a = (ridx_a < IDX_W'(NUM)) ? regs_q[ridx_a] : '0;
    assign rdata_b = (ridx_b < IDX_W'(NUM)) ? regs_q[ridx_b] : '0;

    // R1
    gpr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx == 4'd0) |=> (regs_q[0] == $past(wdata)));
endmodule

// File: rtl/rb_status.sv
// Status word: condition flags, exception number and instruction-set state.
// Assumes the caller gates updates with the run indication.
module rb_status
    import rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             t_load,
    input  logic             t_value,
    input  logic             flags_we,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic             exc_we,
    input  logic [EXC_W-1:0] exc_in,
    input  logic             exec_req,
    output logic [XLEN-1:0]  psr_word,
    output logic             fault
);
    logic [FLAG_W-1:0] flags_q;
    logic [EXC_W-1:0]  exc_q;
    logic              t_q;

    // Field registers; flag and exception writes only once running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            exc_q   <= '0;
            t_q     <= 1'b0;
        end else begin
            if (t_load)              t_q     <= t_value;
            if (running && flags_we) flags_q <= flags_in;
            if (running && exc_we)   exc_q   <= exc_in;
        end
    end

    // Pack the fields; unused bits stay zero.
    always_comb begin
        psr_word = '0;
        psr_word[FLAG_HI -: FLAG_W] = flags_q;
        psr_word[TBIT_POS]          = t_q;
        psr_word[EXC_W-1:0]         = exc_q;
    end

    // Execution with the state bit clear is a fault.
    assign fault = running && exec_req && !t_q;

    // R4
    t_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_load |=> (psr_word[TBIT_POS] == $past(t_value)));
    // R9
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |=> $stable(psr_word[FLAG_HI -: FLAG_W]));
    // R8
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (exec_req && !psr_word[TBIT_POS]));
endmodule

// File: rtl/arch_regbank.sv
// Architectural register bank: data registers, banked stack pointers,
// return-address register, program counter and status word, seeded by a
// two-read boot sequence. Assumes one write per cycle at most per register.
module arch_regbank
    import rb_pkg::*;
#(
    parameter logic [XLEN-1:0] SP_VEC_ADDR = 32'h0000_0000,
    parameter logic [XLEN-1:0] PC_VEC_ADDR = 32'h0000_0004,
    parameter logic [XLEN-1:0] LR_RESET    = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [XLEN-1:0]   rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [XLEN-1:0]   rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              handler_mode,
    input  logic              ctrl_wr_en,
    input  logic              ctrl_spsel_in,
    output logic              ctrl_spsel,
    input  logic              bl_strobe,
    input  logic [XLEN-1:0]   bl_ret_addr,
    input  logic              flags_we,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              exc_we,
    input  logic [EXC_W-1:0]  exc_in,
    output logic [XLEN-1:0]   psr_word,
    input  logic              exec_req,
    output logic              fault,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              running
);
    localparam logic [XLEN-1:0] SP_MASK = ~XLEN'(3);
    localparam logic [XLEN-1:0] PC_MASK = ~XLEN'(1);

    logic [XLEN-1:0] msp_q, psp_q, pc_q, lr_q;
    logic            spsel_q, use_msp, wr_ok, ld_sp, ld_pc;
    logic [XLEN-1:0] gpr_a, gpr_b, sp_view;

    rb_boot_seq #(.SP_ADDR(SP_VEC_ADDR), .PC_ADDR(PC_VEC_ADDR)) u_boot (
        .clk(clk), .rst_n(rst_n), .mem_rvalid(mem_rvalid),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .ld_sp(ld_sp), .ld_pc(ld_pc), .running(running)
    );

    assign wr_ok   = running && wr_en;
    assign use_msp = handler_mode || !spsel_q;
    assign sp_view = use_msp ? msp_q : psp_q;

    rb_gpr_file #(.NUM(NUM_GPR), .W(XLEN)) u_gpr (
        .clk(clk), .rst_n(rst_n),
        .we(wr_ok && (wr_idx < IDX_W'(NUM_GPR))),
        .widx(wr_idx), .wdata(wr_data),
        .ridx_a(rd_a_idx), .ridx_b(rd_b_idx),
        .rdata_a(gpr_a), .rdata_b(gpr_b)
    );

    rb_status u_stat (
        .clk(clk), .rst_n(rst_n), .running(running),
        .t_load(ld_pc), .t_value(mem_rdata[0]),
        .flags_we(flags_we), .flags_in(flags_in),
        .exc_we(exc_we), .exc_in(exc_in),
        .exec_req(exec_req), .psr_word(psr_word), .fault(fault)
    );

    // Banked stack pointers: boot load of main, then steered port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msp_q <= '0;
            psp_q <= '0;
        end else if (ld_sp) begin
            msp_q <= mem_rdata & SP_MASK;
        end else if (wr_ok && wr_idx == IDX_SP) begin
            if (use_msp) msp_q <= wr_data & SP_MASK;
            else         psp_q <= wr_data & SP_MASK;
        end
    end

    // Program counter: boot vector load, then aligned port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                           pc_q <= '0;
        else if (ld_pc)                       pc_q <= mem_rdata & PC_MASK;
        else if (wr_ok && wr_idx == IDX_PC)   pc_q <= wr_data & PC_MASK;
    end

    // Return-address register: strobe has priority over the port.
    always_ff @(posedge clk) begin
        if (!rst_n)                           lr_q <= LR_RESET;
        else if (running && bl_strobe)        lr_q <= bl_ret_addr;
        else if (wr_ok && wr_idx == IDX_LR)   lr_q <= wr_data;
    end

    // Stack select bit, written only once running.
    always_ff @(posedge clk) begin
        if (!rst_n)                     spsel_q <= 1'b0;
        else if (running && ctrl_wr_en) spsel_q <= ctrl_spsel_in;
    end

    assign ctrl_spsel = spsel_q;

    // Read port A index decode.
    always_comb begin
        unique case (rd_a_idx)
            IDX_SP:  rd_a_data = sp_view;
            IDX_LR:  rd_a_data = lr_q;
            IDX_PC:  rd_a_data = pc_q;
            default: rd_a_data = gpr_a;
        endcase
    end

    // Read port B index decode.
    always_comb begin
        unique case (rd_b_idx)
            IDX_SP:  rd_b_data = sp_view;
            IDX_LR:  rd_b_data = lr_q;
            IDX_PC:  rd_b_data = pc_q;
            default: rd_b_data = gpr_b;
        endcase
    end

    // R6
    sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msp_q[1:0] == 2'b00) && (psp_q[1:0] == 2'b00));
    // R6
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_q[0]);
    // R5
    boot_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> ($stable(lr_q) && $stable(spsel_q)));
    // R7
    bl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bl_strobe) |=> (lr_q == $past(bl_ret_addr)));
    // R2
    sp_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == IDX_SP && handler_mode) |-> (rd_a_data == msp_q));
endmodule

// File: tb/sim_arch_regbank.sv
module sim_arch_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, bl_ret_addr = '0;
    logic        wr_en = 0, handler_mode = 0, ctrl_wr_en = 0, ctrl_spsel_in = 0;
    logic        ctrl_spsel, bl_strobe = 0, flags_we = 0, exc_we = 0, exec_req = 0;
    logic [3:0]  flags_in = '0;
    logic [8:0]  exc_in = '0;
    logic [31:0] psr_word, mem_addr, mem_rdata = '0;
    logic        fault, mem_req, mem_rvalid = 0, running;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    arch_regbank u0 (.*);

    typedef struct {
        int          sel;
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t sb[$];

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return rd_a_data;
            1: return rd_b_data;
            2: return psr_word;
            3: return {31'd0, fault};
            4: return {31'd0, mem_req};
            5: return mem_addr;
            6: return {31'd0, running};
            default: return {31'd0, ctrl_spsel};
        endcase
    endfunction

    // Driver side: queue an expectation for just after the next edge.
    task automatic push(int sel, logic [31:0] v, string req);
        exp_t e;
        e.sel = sel; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 0; bl_strobe = 0; ctrl_wr_en = 0; flags_we = 0; exc_we = 0; exec_req = 0;
    endtask

    task automatic wr(logic [3:0] idx, logic [31:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
    endtask

    // Monitor: pop and compare after each rising edge.
    initial begin
        exp_t e;
        logic [31:0] got;
        forever begin
            @(posedge clk);
            #3;
            while (sb.size() > 0) begin
                e = sb.pop_front();
                got = observe(e.sel);
                n_chk++;
                if (got !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", e.req, got, e.val);
                end
            end
        end
    end

    task automatic boot(logic [31:0] spw, logic [31:0] pcw, bit poke);
        rst_n = 1; mem_rvalid = 0;
        push(4, 1, "R4 stack fetch request");
        push(5, 32'h0, "R4 stack fetch address");
        step();
        for (int k = 0; k < 2; k++) begin
            if (poke) begin
                wr(4'd3, 32'h0000_0BAD);
                bl_strobe = 1; bl_ret_addr = 32'h0000_1234;
                ctrl_wr_en = 1; ctrl_spsel_in = 1;
                flags_we = 1; flags_in = 4'hF;
            end
            mem_rdata = 32'hDEAD_BEEF;
            push(5, 32'h0, "R10 address held without valid");
            push(6, 0, "R5 not yet running");
            step();
        end
        quiet();
        mem_rvalid = 1; mem_rdata = spw;
        push(5, 32'h4, "R4 vector fetch address");
        step();
        mem_rvalid = 0; mem_rdata = 32'hCAFE_F00D;
        push(5, 32'h4, "R10 vector address held");
        push(4, 1, "R4 vector request held");
        step();
        mem_rvalid = 1; mem_rdata = pcw;
        push(6, 1, "R4 running after vector");
        push(4, 0, "R10 request drops");
        step();
        mem_rvalid = 0;
    endtask

    initial begin
        step();
        // Reset state
        rd_a_idx = 4'd14;
        push(6, 0, "R3 running low in reset");
        push(7, 0, "R3 select low in reset");
        push(0, 32'hFFFF_FFFF, "R3 return register reset value");
        push(4, 0, "R3 no request in reset");
        step();
        boot(32'h2000_1003, 32'h0000_0101, 1'b1);

        rd_a_idx = 4'd13; rd_b_idx = 4'd15;
        push(0, 32'h2000_1000, "R4 main stack seeded aligned");
        push(1, 32'h0000_0100, "R4 counter seeded bit0 clear");
        push(2, 32'h0100_0000, "R4 state bit set, R5 flags untouched");
        step();
        rd_a_idx = 4'd3; rd_b_idx = 4'd14;
        push(0, 32'h0, "R5 boot write ignored");
        push(1, 32'hFFFF_FFFF, "R5 boot strobe ignored");
        push(7, 0, "R5 boot control ignored");
        step();
        exec_req = 1;
        push(3, 0, "R8 no fault with state bit set");
        step();
        exec_req = 0;

        for (int i = 0; i < 13; i++) begin
            wr(4'(i), 32'h1111_0000 + 32'(i) * 32'h0101);
            step();
        end
        quiet();
        for (int i = 0; i < 13; i++) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(12 - i);
            push(0, 32'h1111_0000 + 32'(i) * 32'h0101, "R1 port A readback");
            push(1, 32'h1111_0000 + 32'(12 - i) * 32'h0101, "R1 port B readback");
            step();
        end

        rd_a_idx = 4'd13;
        wr(4'd13, 32'h2000_0FFF);
        push(0, 32'h2000_0FFC, "R6 main stack write aligned");
        step();
        quiet();
        ctrl_wr_en = 1; ctrl_spsel_in = 1;
        push(7, 1, "R2 select written");
        push(0, 32'h0, "R2 thread select 1 sees process stack");
        step();
        quiet();
        wr(4'd13, 32'h1000_0003);
        push(0, 32'h1000_0000, "R6 process stack write aligned");
        step();
        quiet();
        handler_mode = 1;
        push(0, 32'h2000_0FFC, "R2 handler sees main stack");
        step();
        wr(4'd13, 32'h3000_0006);
        push(0, 32'h3000_0004, "R2 handler write reaches main stack");
        step();
        quiet(); handler_mode = 0;
        push(0, 32'h1000_0000, "R2 process stack untouched by handler write");
        step();

        rd_b_idx = 4'd15;
        wr(4'd15, 32'h0000_0203);
        push(1, 32'h0000_0202, "R6 counter write bit0 clear");
        step();
        rd_b_idx = 4'd14;
        wr(4'd14, 32'h0000_0055); bl_strobe = 1; bl_ret_addr = 32'h0000_0301;
        push(1, 32'h0000_0301, "R7 strobe beats port write");
        step();
        quiet();
        wr(4'd14, 32'h0000_0777);
        push(1, 32'h0000_0777, "R7 port write to return register");
        step();
        quiet();
        bl_strobe = 1; bl_ret_addr = 32'h0000_0401;
        push(1, 32'h0000_0401, "R7 strobe alone");
        step();
        quiet();

        flags_we = 1; flags_in = 4'b1010; exc_we = 1; exc_in = 9'h1FF;
        push(2, 32'hA100_01FF, "R9 status layout");
        step();
        flags_we = 0; flags_in = 4'h5; exc_in = 9'h003;
        push(2, 32'hA100_0003, "R9 exception field alone");
        step();
        quiet();

        handler_mode = 1; rd_a_idx = 4'd13; rd_b_idx = 4'd15;
        mem_rvalid = 1; mem_rdata = 32'hFFFF_FFFF;
        push(0, 32'h3000_0004, "R10 stray valid leaves stack");
        push(1, 32'h0000_0202, "R10 stray valid leaves counter");
        push(4, 0, "R10 no request when running");
        step();
        mem_rvalid = 0; handler_mode = 0;

        rst_n = 0; rd_a_idx = 4'd14;
        push(7, 0, "R3 select cleared by reset");
        push(6, 0, "R3 running cleared by reset");
        push(0, 32'hFFFF_FFFF, "R3 return register reset again");
        step();
        step();
        boot(32'h0000_8000, 32'h0000_0200, 1'b0);
        exec_req = 1;
        push(3, 1, "R8 fault with state bit clear");
        push(2, 32'h0, "R9 status after second boot");
        step();
        exec_req = 0;
        push(3, 0, "R8 fault follows request");
        step();
        step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule